// File: doc/BRIEF.md
# Infrared Transmit Line Conditioner

This block sits between an infrared-capable UART and the LED driver pin. The serial transmit data can pass straight through. It can also be chopped by a carrier near 38 kHz. The carrier is made by dividing the system clock, whose nominal rate is 4.9152 MHz. A two-bit field sets what share of each carrier period the pin is pulled low. The carrier is applied only while the UART line is at its space (0) level. At mark or idle the pin rests at its inactive high level.

A polarity bit can invert the conditioned UART path. A source selector can instead route a general-purpose output bit or an energy pulse signal to the pin. The pin level is registered, so it follows its inputs with one clock of latency. A separate bit inverts the received infrared input before it reaches the UART; that path is combinational.

While the low-power battery flag is set, the modulation enable is ignored. The carrier divider is held cleared whenever modulation is not active, so the first carrier period after enabling is always complete. Every interface here is a plain level signal; there is no data stream and so no valid/ready handshake or back-pressure.

Top module: `ir_tx_cond`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, `tx_pin` is 1.
- R2: With `mod_en` = 0, `tx_inv` = 0 and `out_sel` = 00, `tx_pin` equals `uart_txd` one clock earlier.
- R3: With modulation active and `uart_txd` held at 0, `tx_pin` repeats with a period of `PERIOD` clocks (default 129).
- R4: In each carrier period the number of low clocks is `PERIOD >> (duty_sel + 1)`. With the default period that is 64, 32, 16 or 8 for `duty_sel` = 0, 1, 2, 3. The low clocks come first in the period.
- R5: With modulation active and `uart_txd` = 1, the UART path stays at 1, so `tx_pin` = 1 when uninverted.
- R6: While `lowpwr` = 1, `mod_en` has no effect and the UART path passes `uart_txd` through unmodulated.
- R7: The carrier restarts from its first low clock on the first output cycle after modulation becomes active.
- R8: `tx_inv` = 1 inverts the UART path, including its carrier pulses.
- R9: `rx_to_uart` equals `rx_pin` XOR `rx_inv`, combinationally.
- R10: `out_sel` chooses the source with one clock of latency. The codes are 00 for the UART path, 01 for `gpo_bit`, 10 for `epulse` and 11 for the UART path. `tx_inv` does not affect `gpo_bit` or `epulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_txd | input | 1 | Serial data from the UART (0 = space) |
| gpo_bit | input | 1 | General-purpose output level |
| epulse | input | 1 | Energy pulse signal |
| lowpwr | input | 1 | Battery low-power mode flag; blocks modulation |
| mod_en | input | 1 | Carrier modulation enable |
| duty_sel | input | 2 | Carrier low-time select |
| tx_inv | input | 1 | Invert the UART transmit path |
| rx_inv | input | 1 | Invert the receive input |
| out_sel | input | 2 | Pin source select |
| rx_pin | input | 1 | Received infrared level |
| rx_to_uart | output | 1 | Conditioned receive level to the UART |
| tx_pin | output | 1 | Registered pin drive level |

## Verification
The transmit path is exercised with several input patterns:
- An alternating data pattern with modulation off shows plain pass-through.
- A long run of space bits under each duty setting exposes the carrier period and the low-clock count. This separates the four duty codes from one another.
- Held mark bits under modulation show whether the carrier leaks into idle.
- Requesting modulation while the low-power flag is set shows whether that flag is honoured.
- Toggling the enable shows whether the divider restarts cleanly.
- Walking the source selector and the inversion bits shows routing, and shows that inversion is confined to the UART path.

// File: rtl/ir_txc_pkg.sv
package ir_txc_pkg;
  typedef enum logic [1:0] {
    SRC_UART     = 2'b00,
    SRC_GPO      = 2'b01,
    SRC_PULSE    = 2'b10,
    SRC_UART_ALT = 2'b11
  } src_sel_e;
endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int PERIOD = 129,
  parameter int DUTY_W = 2,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DUTY_W-1:0] duty_sel,
  output logic [CW-1:0]     cnt,
  output logic              car_low
);
  localparam int NDUTY = 1 << DUTY_W;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] low_tbl [NDUTY];

  for (genvar g = 0; g < NDUTY; g++) begin : g_low
    assign low_tbl[g] = CW'(PERIOD >> (g + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign car_low = cnt < low_tbl[duty_sel];
endmodule

// File: rtl/ir_tx_shaper.sv
module ir_tx_shaper (
  input  logic run,
  input  logic txd,
  input  logic car_low,
  input  logic inv,
  output logic shaped
);
  logic raw;
  always_comb begin
    if (run && !txd) raw = !car_low;
    else             raw = txd;
    shaped = raw ^ inv;
  end
endmodule

// File: rtl/ir_out_mux.sv
module ir_out_mux
  import ir_txc_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             uart_path,
  input  logic             gpo,
  input  logic             pulse,
  output logic             pin
);
  logic nxt;
  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_GPO:   nxt = gpo;
      SRC_PULSE: nxt = pulse;
      default:   nxt = uart_path;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b1;
    else        pin <= nxt;
  end
endmodule

// File: rtl/ir_tx_cond.sv
module ir_tx_cond #(
  parameter int PERIOD = 129,
  parameter int DUTY_W = 2,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_txd,
  input  logic              gpo_bit,
  input  logic              epulse,
  input  logic              lowpwr,
  input  logic              mod_en,
  input  logic [DUTY_W-1:0] duty_sel,
  input  logic              tx_inv,
  input  logic              rx_inv,
  input  logic [SEL_W-1:0]  out_sel,
  input  logic              rx_pin,
  output logic              rx_to_uart,
  output logic              tx_pin
);
  localparam int CW = $clog2(PERIOD);

  logic          mod_run;
  logic [CW-1:0] car_cnt;
  logic          car_low;
  logic          uart_path;

  // low-power mode overrides the modulation request
  assign mod_run = mod_en && !lowpwr;

  ir_carrier_gen #(.PERIOD(PERIOD), .DUTY_W(DUTY_W)) u_car (
    .clk(clk), .rst_n(rst_n), .run(mod_run), .duty_sel(duty_sel),
    .cnt(car_cnt), .car_low(car_low)
  );

  ir_tx_shaper u_shp (
    .run(mod_run), .txd(uart_txd), .car_low(car_low), .inv(tx_inv),
    .shaped(uart_path)
  );

  ir_out_mux #(.SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .sel(out_sel), .uart_path(uart_path),
    .gpo(gpo_bit), .pulse(epulse), .pin(tx_pin)
  );

  assign rx_to_uart = rx_pin ^ rx_inv;
endmodule

// File: rtl/ir_tx_cond_chk.sv
module ir_tx_cond_chk #(
  parameter int PERIOD = 129,
  parameter int CW = $clog2(PERIOD)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uart_txd,
  input logic          gpo_bit,
  input logic          epulse,
  input logic          lowpwr,
  input logic          mod_en,
  input logic          tx_inv,
  input logic [1:0]    out_sel,
  input logic [CW-1:0] car_cnt,
  input logic          tx_pin
);
  // R2: plain pass-through
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !tx_inv && out_sel == 2'b00) |=> tx_pin == $past(uart_txd));
  // R5: mark level never carries the carrier
  a_r5_mark_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && uart_txd && !tx_inv && out_sel == 2'b00) |=> tx_pin);
  // R6: low-power flag blocks modulation
  a_r6_lowpwr_block: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr && !tx_inv && out_sel == 2'b00) |=> tx_pin == $past(uart_txd));
  // R7: divider held cleared while modulation is off
  a_r7_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_en && !lowpwr) |=> car_cnt == '0);
  // R3: divider stays inside one period
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(car_cnt) < PERIOD);
  // R10: selected GPO and pulse sources
  a_r10_gpo: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel == 2'b01 |=> tx_pin == $past(gpo_bit));
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel == 2'b10 |=> tx_pin == $past(epulse));
endmodule

bind ir_tx_cond ir_tx_cond_chk #(.PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .uart_txd(uart_txd), .gpo_bit(gpo_bit),
  .epulse(epulse), .lowpwr(lowpwr), .mod_en(mod_en), .tx_inv(tx_inv),
  .out_sel(out_sel), .car_cnt(car_cnt), .tx_pin(tx_pin)
);

// File: tb/tb_ir_tx_cond.sv
module tb_ir_tx_cond;
  localparam int P = 129;

  logic clk = 0, rst_n = 0;
  logic uart_txd = 1, gpo_bit = 0, epulse = 0, lowpwr = 0, mod_en = 0;
  logic [1:0] duty_sel = 0, out_sel = 0;
  logic tx_inv = 0, rx_inv = 0, rx_pin = 0;
  logic rx_to_uart, tx_pin;

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt = 0;
  logic exp_pin = 1;
  string cur_req = "R1";

  always #5 clk = ~clk;

  ir_tx_cond dut (.*);

  // behavioural reference, evaluated on inputs stable at the edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      exp_pin = 1; m_cnt = 0;
    end else begin
      bit run, lowph, up;
      run = mod_en && !lowpwr;
      lowph = m_cnt < (P >> (duty_sel + 1));
      up = ((run && !uart_txd) ? !lowph : uart_txd) ^ tx_inv;
      case (out_sel)
        2'b01: exp_pin = gpo_bit;
        2'b10: exp_pin = epulse;
        default: exp_pin = up;
      endcase
      m_cnt = run ? (m_cnt + 1) % P : 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    checks++;
    if (tx_pin !== exp_pin) begin
      fails++;
      $display("FAIL %s cycle %0d tx_pin actual=%0b expected=%0b", cur_req, cyc, tx_pin, exp_pin);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count low clocks over one period right after enabling (R4, R7)
  task automatic duty_run(int d);
    int lows = 0;
    bit first;
    @(negedge clk); mod_en = 0; duty_sel = 2'(d); uart_txd = 0;
    @(negedge clk); mod_en = 1;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (i == 0) first = (tx_pin == 0);
      if (tx_pin == 0) lows++;
    end
    chk("R4", lows, P >> (d + 1));
    chk("R7", first, 1);
  endtask

  initial begin
    cur_req = "R1";
    step(3);
    chk("R1", tx_pin, 1);
    rst_n = 1;
    step(1);
    chk("R1", tx_pin, 1);

    cur_req = "R2";
    for (int i = 0; i < 40; i++) begin
      uart_txd = i[0] ^ i[2]; step(1);
    end

    cur_req = "R3";
    uart_txd = 0; mod_en = 1; duty_sel = 1;
    step(3 * P);

    cur_req = "R4";
    for (int d = 0; d < 4; d++) duty_run(d);

    cur_req = "R5";
    uart_txd = 1; step(2 * P);

    cur_req = "R7";
    uart_txd = 0; step(50); mod_en = 0; step(3); mod_en = 1; step(P + 10);

    cur_req = "R6";
    lowpwr = 1;
    for (int i = 0; i < 60; i++) begin
      uart_txd = i[1]; step(1);
    end
    lowpwr = 0; uart_txd = 0; step(P);

    cur_req = "R8";
    tx_inv = 1; step(P + 5); mod_en = 0; uart_txd = 1; step(5); uart_txd = 0; step(5);

    cur_req = "R10";
    for (int s = 0; s < 4; s++) begin
      out_sel = 2'(s);
      for (int i = 0; i < 12; i++) begin
        gpo_bit = i[0]; epulse = i[1]; uart_txd = i[2]; step(1);
      end
    end
    tx_inv = 0; out_sel = 0;

    cur_req = "R9";
    for (int i = 0; i < 4; i++) begin
      rx_pin = i[0]; rx_inv = i[1]; #1;
      chk("R9", rx_to_uart, i[0] ^ i[1]);
    end
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule